// File: doc/BRIEF.md
# Serial Hold Condition Controller

This block is the pause logic of a serial slave interface. It watches an active-low hold pin, the serial clock and the chip select. From them it produces three signals for the rest of the slave. The first is a pause flag. The second is a shift strobe that advances the slave's bit counter and shift register. The third is an output-enable permission for the data output driver. All pins are brought into a fast system clock domain through two-flop synchronizers, and edges are found there.

A pause is requested by a falling hold pin while the device is selected. It takes effect only at a point where the serial clock is low. Its release is qualified in the same way. While paused, serial clock edges do not shift and the output driver is not allowed on. A select that rises during a pause resets the serial interface with a one-cycle pulse. The interface then stays locked until hold has been released and the device has been selected again. The function is turned off by a configuration enable bit, and also while the hold pin is reused as a quad data line. The busy flag of the internal program/erase engine passes through unaffected by any pause.

Top module: `hold_pause_ctrl`

## Requirements
- R1: After reset, pause_active, shift_en and iface_rst are 0, and dout_oe is 0 while cs_n is high.
- R2: A falling hold_n while cs_n is high never starts a pause.
- R3: With cs_n low, a falling hold_n while sclk is low raises pause_active. A pin change reaches the state-based outputs on the third system clock edge after it is sampled, and reaches shift_en on the second.
- R4: With cs_n low, a falling hold_n while sclk is high leaves pause_active at 0 until sclk goes low. Only then does the pause begin.
- R5: A rising hold_n during a pause ends it at once if sclk is low. If sclk is high, the end is deferred until sclk next goes low.
- R6: While pause_active is 1, shift_en and dout_oe stay 0 whatever sclk does.
- R7: cs_n rising during a pause raises iface_rst for exactly one system clock and clears pause_active. After that, shift_en and dout_oe stay 0 until hold_n is high with cs_n high and cs_n is then driven low.
- R8: With cfg_hold_en = 0, hold_n has no effect. Clearing it during a pause ends the pause on the next state update, without waiting for sclk.
- R9: With quad_io_mode = 1, the hold pin is treated as a data line, and hold_n cannot start or keep a pause.
- R10: busy_out equals busy_in delayed by two system clocks, whether or not a pause is active.
- R11: Outside a pause and lockout, with cs_n low, shift_en pulses for one system clock per sclk rising edge, and dout_oe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock pin (asynchronous) |
| cs_n | input | 1 | Chip select pin, active low |
| hold_n | input | 1 | Hold pin, active low |
| cfg_hold_en | input | 1 | Hold function enable, 1 = enabled |
| quad_io_mode | input | 1 | 1 = hold pin in use as quad data line |
| busy_in | input | 1 | Program/erase engine busy |
| pause_active | output | 1 | Pause in effect |
| shift_en | output | 1 | One-cycle strobe per accepted sclk rising edge |
| dout_oe | output | 1 | Data output driver permitted |
| iface_rst | output | 1 | One-cycle serial interface reset |
| busy_out | output | 1 | Synchronized busy, independent of pause |

## Verification
The bench targets hold edges that land while sclk is high. A design that skipped the deferral would pause or resume in mid-bit and corrupt the shifted byte. It deselects during a pause and then reselects with hold still low. A design without the lockout would let the slave resume with stale state or drive the output. It also clears the enable bit and enters quad mode around a pause. A design that ignored them would freeze a quad transfer on data activity.

// File: rtl/hp_pkg.sv
package hp_pkg;

    typedef enum logic [2:0] {
        HP_RUN        = 3'd0,
        HP_PEND_START = 3'd1,
        HP_PAUSED     = 3'd2,
        HP_PEND_END   = 3'd3,
        HP_LOCKED     = 3'd4,
        HP_REARM      = 3'd5
    } hp_state_e;

    typedef struct packed {
        logic sclk;
        logic csn;
        logic holdn;
        logic en;
        logic quad;
        logic busy;
    } hp_pins_t;

    localparam int HP_PIN_W = $bits(hp_pins_t);

    localparam hp_pins_t HP_PINS_IDLE = '{
        sclk: 1'b0, csn: 1'b1, holdn: 1'b1, en: 1'b1, quad: 1'b0, busy: 1'b0
    };

    function automatic logic hp_is_paused(hp_state_e s);
        return (s == HP_PAUSED) || (s == HP_PEND_END);
    endfunction

    function automatic logic hp_is_live(hp_state_e s);
        return (s == HP_RUN) || (s == HP_PEND_START);
    endfunction

    function automatic logic hp_hold_eff(hp_pins_t p);
        return p.holdn | ~(p.en & ~p.quad);
    endfunction

endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/hp_fsm.sv
module hp_fsm
    import hp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  hp_pins_t cur,
    input  hp_pins_t prv,
    input  logic     func_on,
    output logic     pause_active,
    output logic     shift_en,
    output logic     dout_oe,
    output logic     iface_rst
);
    hp_state_e st, nxt;
    logic      rst_nxt;
    logic      he, phe, h_fall, h_rise, sck_rise;

    assign he       = hp_hold_eff(cur);
    assign phe      = hp_hold_eff(prv);
    assign h_fall   = phe & ~he;
    assign h_rise   = ~phe & he;
    assign sck_rise = cur.sclk & ~prv.sclk;

    always_comb begin
        nxt     = st;
        rst_nxt = 1'b0;
        unique case (st)
            HP_RUN: begin
                if (!cur.csn && h_fall)
                    nxt = cur.sclk ? HP_PEND_START : HP_PAUSED;
            end
            HP_PEND_START: begin
                if (cur.csn || he)  nxt = HP_RUN;
                else if (!cur.sclk) nxt = HP_PAUSED;
            end
            HP_PAUSED, HP_PEND_END: begin
                if (cur.csn) begin
                    nxt     = HP_LOCKED;
                    rst_nxt = 1'b1;
                end else if (!func_on) begin
                    nxt = HP_RUN;
                end else if (st == HP_PEND_END) begin
                    if (!cur.sclk) nxt = HP_RUN;
                end else if (h_rise) begin
                    nxt = cur.sclk ? HP_PEND_END : HP_RUN;
                end
            end
            HP_LOCKED: begin
                if (he && cur.csn) nxt = HP_REARM;
            end
            HP_REARM: begin
                if (!he)           nxt = HP_LOCKED;
                else if (!cur.csn) nxt = HP_RUN;
            end
            default: nxt = HP_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= HP_RUN;
            iface_rst <= 1'b0;
        end else begin
            st        <= nxt;
            iface_rst <= rst_nxt;
        end
    end

    assign pause_active = hp_is_paused(st);
    assign dout_oe      = hp_is_live(st) & ~cur.csn;
    assign shift_en     = dout_oe & sck_rise;
endmodule

// File: rtl/hold_pause_ctrl.sv
module hold_pause_ctrl
    import hp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    input  logic hold_n,
    input  logic cfg_hold_en,
    input  logic quad_io_mode,
    input  logic busy_in,
    output logic pause_active,
    output logic shift_en,
    output logic dout_oe,
    output logic iface_rst,
    output logic busy_out
);
    hp_pins_t raw, s_cur, s_prv;
    logic [HP_PIN_W-1:0] s_vec;
    logic func_on;

    assign raw = '{sclk: sclk, csn: cs_n, holdn: hold_n,
                   en: cfg_hold_en, quad: quad_io_mode, busy: busy_in};

    hp_sync #(
        .WIDTH  (HP_PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(HP_PINS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din (raw),
        .dout(s_vec)
    );

    assign s_cur = hp_pins_t'(s_vec);

    always_ff @(posedge clk) begin
        if (rst) s_prv <= HP_PINS_IDLE;
        else     s_prv <= s_cur;
    end

    assign func_on = s_cur.en & ~s_cur.quad;

    hp_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cur         (s_cur),
        .prv         (s_prv),
        .func_on     (func_on),
        .pause_active(pause_active),
        .shift_en    (shift_en),
        .dout_oe     (dout_oe),
        .iface_rst   (iface_rst)
    );

    assign busy_out = s_cur.busy;
endmodule

// File: rtl/hp_pause_chk.sv
module hp_pause_chk (
    input logic clk,
    input logic rst,
    input logic pause_active,
    input logic shift_en,
    input logic dout_oe,
    input logic iface_rst,
    input logic func_on
);
    AST_PAUSE_SILENT: assert property (@(posedge clk) disable iff (rst)
        pause_active |-> (!shift_en && !dout_oe)); // R6

    AST_RST_SINGLE: assert property (@(posedge clk) disable iff (rst)
        iface_rst |=> !iface_rst); // R7

    AST_RST_FROM_PAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(iface_rst) |-> ($past(pause_active) && !pause_active)); // R7

    AST_OFF_NO_PAUSE: assert property (@(posedge clk) disable iff (rst)
        !func_on |=> !pause_active); // R8

    AST_SHIFT_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
        shift_en |-> dout_oe); // R11
endmodule

bind hold_pause_ctrl hp_pause_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pause_active(pause_active),
    .shift_en    (shift_en),
    .dout_oe     (dout_oe),
    .iface_rst   (iface_rst),
    .func_on     (func_on)
);

// File: tb/tb_hold_pause_ctrl.sv
`timescale 1ns/1ps
module tb_hold_pause_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, cs_n = 1'b1, hold_n = 1'b1;
    logic cfg_hold_en = 1'b1, quad_io_mode = 1'b0, busy_in = 1'b0;
    logic pause_active, shift_en, dout_oe, iface_rst, busy_out;

    int n_run = 0, n_fail = 0;
    int shifts = 0, rsts = 0, cyc_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hold_pause_ctrl dut (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .hold_n(hold_n),
        .cfg_hold_en(cfg_hold_en), .quad_io_mode(quad_io_mode), .busy_in(busy_in),
        .pause_active(pause_active), .shift_en(shift_en), .dout_oe(dout_oe),
        .iface_rst(iface_rst), .busy_out(busy_out)
    );

    // Reference model: input history as bit arrays [0]=just sampled,[1]=synced,[2]=previous synced
    bit q_sck[3], q_cs[3], q_hd[3], q_en[3], q_qd[3], q_bz[3];
    bit m_paused, m_wait_lo_start, m_wait_lo_end, m_locked, m_rearm, m_rst;

    function automatic bit held(int k);
        return ~q_hd[k] & q_en[k] & ~q_qd[k];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 3; k++) begin
                q_sck[k] = 0; q_cs[k] = 1; q_hd[k] = 1; q_en[k] = 1; q_qd[k] = 0; q_bz[k] = 0;
            end
            {m_paused, m_wait_lo_start, m_wait_lo_end, m_locked, m_rearm, m_rst} = '0;
        end else begin
            bit on, cs, sk, fell, rose;
            on   = q_en[1] & ~q_qd[1];
            cs   = q_cs[1];
            sk   = q_sck[1];
            fell = held(1) & ~held(2);
            rose = ~held(1) & held(2);
            m_rst = 0;
            if (m_locked) begin
                if (!held(1) && cs) begin m_locked = 0; m_rearm = 1; end
            end else if (m_rearm) begin
                if (held(1)) begin m_rearm = 0; m_locked = 1; end
                else if (!cs) m_rearm = 0;
            end else if (m_paused) begin
                if (cs) begin m_paused = 0; m_wait_lo_end = 0; m_locked = 1; m_rst = 1; end
                else if (!on) begin m_paused = 0; m_wait_lo_end = 0; end
                else if (m_wait_lo_end) begin
                    if (!sk) begin m_paused = 0; m_wait_lo_end = 0; end
                end else if (rose) begin
                    if (sk) m_wait_lo_end = 1; else m_paused = 0;
                end
            end else if (m_wait_lo_start) begin
                if (cs || !held(1)) m_wait_lo_start = 0;
                else if (!sk) begin m_wait_lo_start = 0; m_paused = 1; end
            end else if (!cs && fell) begin
                if (sk) m_wait_lo_start = 1; else m_paused = 1;
            end
            for (int k = 2; k > 0; k--) begin
                q_sck[k] = q_sck[k-1]; q_cs[k] = q_cs[k-1]; q_hd[k] = q_hd[k-1];
                q_en[k] = q_en[k-1]; q_qd[k] = q_qd[k-1]; q_bz[k] = q_bz[k-1];
            end
            q_sck[0] = sclk; q_cs[0] = cs_n; q_hd[0] = hold_n;
            q_en[0] = cfg_hold_en; q_qd[0] = quad_io_mode; q_bz[0] = busy_in;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // every-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit live, e_oe;
            live = ~(m_paused | m_locked | m_rearm);
            e_oe = live & ~q_cs[1];
            chk("R3 model pause_active", pause_active, m_paused);
            chk("R11 model shift_en", shift_en, e_oe & q_sck[1] & ~q_sck[2]);
            chk("R6 model dout_oe", dout_oe, e_oe);
            chk("R7 model iface_rst", iface_rst, m_rst);
            chk("R10 model busy_out", busy_out, q_bz[1]);
            if (shift_en) shifts++;
            if (iface_rst) rsts++;
        end
    end

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 100000 && !done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<=100000 cycles", cyc_cnt);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sclk_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b1; cyc(4);
            sclk = 1'b0; cyc(4);
        end
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        chk("R1 pause_active", pause_active, 1'b0);
        chk("R1 shift_en", shift_en, 1'b0);
        chk("R1 dout_oe", dout_oe, 1'b0);
        chk("R1 iface_rst", iface_rst, 1'b0);

        // R11 normal shifting
        cs_n = 1'b0; cyc(4);
        chk("R11 dout_oe selected", dout_oe, 1'b1);
        shifts = 0;
        sclk_pulses(4);
        chk("R11 shift count", shifts == 4, 1'b1);

        // R2 hold falls while deselected
        cs_n = 1'b1; cyc(4);
        hold_n = 1'b0; cyc(5);
        chk("R2 no pause deselected", pause_active, 1'b0);
        cs_n = 1'b0; cyc(5);
        chk("R2 still no pause", pause_active, 1'b0);
        hold_n = 1'b1; cyc(5);

        // R3 immediate start, R6 ignore sclk, R10 busy passes
        hold_n = 1'b0; cyc(2);
        chk("R3 not before third edge", pause_active, 1'b0);
        cyc(1);
        chk("R3 pause at third edge", pause_active, 1'b1);
        shifts = 0;
        sclk_pulses(3);
        chk("R6 no shifts paused", shifts == 0, 1'b1);
        chk("R6 oe off paused", dout_oe, 1'b0);
        busy_in = 1'b1; cyc(2);
        chk("R10 busy during pause", busy_out, 1'b1);
        busy_in = 1'b0; cyc(2);
        chk("R10 busy clear during pause", busy_out, 1'b0);

        // R5 immediate end with sclk low
        hold_n = 1'b1; cyc(4);
        chk("R5 end with sclk low", pause_active, 1'b0);

        // R4 deferred start
        sclk = 1'b1; cyc(4);
        hold_n = 1'b0; cyc(6);
        chk("R4 deferred while sclk high", pause_active, 1'b0);
        sclk = 1'b0; cyc(4);
        chk("R4 starts on sclk low", pause_active, 1'b1);

        // R5 deferred end
        sclk = 1'b1; cyc(4);
        hold_n = 1'b1; cyc(6);
        chk("R5 held while sclk high", pause_active, 1'b1);
        sclk = 1'b0; cyc(4);
        chk("R5 ends on sclk low", pause_active, 1'b0);

        // R7 deselect during pause
        hold_n = 1'b0; cyc(5);
        chk("R7 paused before deselect", pause_active, 1'b1);
        rsts = 0;
        cs_n = 1'b1; cyc(6);
        chk("R7 one reset pulse", rsts == 1, 1'b1);
        chk("R7 pause cleared", pause_active, 1'b0);
        cs_n = 1'b0; cyc(5);
        shifts = 0;
        sclk_pulses(2);
        chk("R7 locked no shift", shifts == 0, 1'b1);
        chk("R7 locked no oe", dout_oe, 1'b0);
        hold_n = 1'b1; cyc(5);
        chk("R7 hold high while selected stays locked", dout_oe, 1'b0);
        cs_n = 1'b1; cyc(5);
        cs_n = 1'b0; cyc(5);
        chk("R7 reselect unlocks", dout_oe, 1'b1);

        // R8 disabled
        cfg_hold_en = 1'b0; cyc(4);
        hold_n = 1'b0; cyc(6);
        chk("R8 no pause when disabled", pause_active, 1'b0);
        chk("R8 oe stays on", dout_oe, 1'b1);
        hold_n = 1'b1; cyc(4);
        cfg_hold_en = 1'b1; cyc(4);
        // R8 disable mid-pause with sclk high
        hold_n = 1'b0; cyc(5);
        sclk = 1'b1; cyc(4);
        chk("R8 paused before clear", pause_active, 1'b1);
        cfg_hold_en = 1'b0; cyc(4);
        chk("R8 clear ends pause at once", pause_active, 1'b0);
        sclk = 1'b0; hold_n = 1'b1; cyc(4);
        cfg_hold_en = 1'b1; cyc(4);

        // R9 quad reuse
        quad_io_mode = 1'b1; cyc(4);
        hold_n = 1'b0; cyc(6);
        chk("R9 no pause in quad mode", pause_active, 1'b0);
        hold_n = 1'b1; cyc(4);
        quad_io_mode = 1'b0; cyc(4);
        chk("R9 oe after quad", dout_oe, 1'b1);

        cs_n = 1'b1; cyc(5);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule